// File: doc/BRIEF.md
# Fault Input Qualifier with Shared Open-Drain Fault Line

This block watches two fault sources for a bank of up to 16 supply rails. The first source is a general-purpose fault input. The second is a wired, active-low fault line that several controllers share. Each source goes through its own deglitch filter, which counts a slow time-base tick (nominally 500 µs) against a 16-bit glitch limit. A source is used only when its enable bit is set and its pin-select valid flag is set.

A qualified fault event is a filtered transition from the asserted level to the deasserted level. On such an event the block emits a one-cycle response request. The request carries the source's 16-bit rail response mask, in which bit n selects rail n. The actions the rails then take belong to other logic.

The same shared line also works as an output. While any rail enabled in the output mask reports an internal fault, the block pulls the line low. The block does not react to its own pull. A debug flag suppresses all response requests.

Top module: `flt_share_ctrl`

## Requirements
- R1: After reset, `resp_req_o` is 0, `resp_mask_o` is all zeros and `line_pull_o` is 0.
- R2: When an enabled source's filtered level goes from asserted to deasserted, `resp_req_o` is high for exactly one cycle. A filtered change from deasserted to asserted raises no request.
- R3: The input level is registered once. A new registered level is accepted on the tick where it has already differed from the filtered level for `glitch`+1 ticks, so it must be stable for more than `glitch` ticks. A pulse shorter than that leaves the filtered level unchanged. With a tick on every cycle, a step on the raw GPI input gives a request `glitch`+2 clock edges later.
- R4: During a request, `resp_mask_o` equals the response mask of the source that fired, where bit n = 1 means rail n responds. When no request is present, `resp_mask_o` is zero.
- R5: `line_pull_o` is 1 in the cycle after any bit of `rail_fault_i & line_out_mask_i` is set. It is 0 in the cycle after no such bit is set.
- R6: A source whose enable or pin-select valid flag is 0 produces no request. Its filter is held at the asserted level.
- R7: While `line_pull_o` is 1, the line monitor treats the line as asserted, so the block's own pull never raises a request.
- R8: When `debug_i` is high at a clock edge, no request is issued at that edge. Debug mode does not affect `line_pull_o`.
- R9: If both sources qualify an event at the same edge, the block issues a single one-cycle request whose mask is the OR of both response masks.
- R10: Polarity: the GPI input is asserted when high, and the shared line is asserted when high (released). A low level on either input is the deasserted level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Deglitch time-base pulse (500 µs) |
| gpi_raw_i | input | 1 | Raw GPI fault input level |
| gpi_en_i | input | 1 | GPI fault function enable |
| gpi_sel_vld_i | input | 1 | GPI pin selection is non-zero |
| gpi_glitch_i | input | 16 | GPI glitch limit in ticks |
| gpi_resp_mask_i | input | 16 | Rails that respond to a GPI event |
| line_in_i | input | 1 | Sensed level of the shared fault line |
| line_en_i | input | 1 | Shared-line fault function enable |
| line_sel_vld_i | input | 1 | Shared-line pin selection is non-zero |
| line_glitch_i | input | 16 | Shared-line glitch limit in ticks |
| line_resp_mask_i | input | 16 | Rails that respond to a line event |
| line_out_mask_i | input | 16 | Rails whose faults pull the line low |
| rail_fault_i | input | 16 | Per-rail internal fault flags |
| debug_i | input | 1 | Debug mode: suppress response requests |
| resp_req_o | output | 1 | One-cycle fault response request |
| resp_mask_o | output | 16 | Rails addressed by the request |
| line_pull_o | output | 1 | 1 = drive the shared line low |

## Verification
The GPI filter and the line filter can qualify a deasserting edge at the same clock edge. The result must then be one merged request, not two pulses or a lost mask. The bench provokes this directly by dropping both inputs at the same cycle with equal glitch limits and a tick every cycle. It expects exactly one pulse carrying the OR of the two distinct response masks. The random phase also lets the two sources drift into coincidence under random ticks and glitch limits. There, a cycle-by-cycle reference built from the requirements judges every request and mask.

// File: rtl/flt_share_pkg.sv
package flt_share_pkg;
    localparam int unsigned RAILS_DEF    = 16;
    localparam int unsigned GLITCH_W_DEF = 16;
    localparam int unsigned N_SRC        = 2;
    localparam int unsigned SRC_GPI      = 0;
    localparam int unsigned SRC_LINE     = 1;
endpackage

// File: rtl/flt_deglitch.sv
module flt_deglitch #(
    parameter int unsigned GW = flt_share_pkg::GLITCH_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          tick_i,
    input  logic          level_i,
    input  logic [GW-1:0] glitch_i,
    output logic          fall_o
);
    typedef struct packed {
        logic          sync;
        logic          filt;
        logic [GW-1:0] cnt;
    } dg_state_t;

    dg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        fall_o    = 1'b0;
        st_d.sync = level_i;
        if (!active_i) begin
            st_d.filt = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.sync == st_q.filt) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt >= glitch_i) begin
                st_d.filt = st_q.sync;
                st_d.cnt  = '0;
                fall_o    = st_q.filt;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sync: 1'b1, filt: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/flt_line_drv.sv
module flt_line_drv #(
    parameter int unsigned N_RAILS = flt_share_pkg::RAILS_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] rail_fault_i,
    input  logic [N_RAILS-1:0] out_mask_i,
    output logic               pull_o
);
    logic pull_d, pull_q;

    always_comb begin
        pull_d = |(rail_fault_i & out_mask_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_q <= 1'b0;
        end else begin
            pull_q <= pull_d;
        end
    end

    assign pull_o = pull_q;
endmodule

// File: rtl/flt_share_ctrl.sv
module flt_share_ctrl
    import flt_share_pkg::*;
#(
    parameter int unsigned N_RAILS = RAILS_DEF,
    parameter int unsigned GW      = GLITCH_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               gpi_raw_i,
    input  logic               gpi_en_i,
    input  logic               gpi_sel_vld_i,
    input  logic [GW-1:0]      gpi_glitch_i,
    input  logic [N_RAILS-1:0] gpi_resp_mask_i,
    input  logic               line_in_i,
    input  logic               line_en_i,
    input  logic               line_sel_vld_i,
    input  logic [GW-1:0]      line_glitch_i,
    input  logic [N_RAILS-1:0] line_resp_mask_i,
    input  logic [N_RAILS-1:0] line_out_mask_i,
    input  logic [N_RAILS-1:0] rail_fault_i,
    input  logic               debug_i,
    output logic               resp_req_o,
    output logic [N_RAILS-1:0] resp_mask_o,
    output logic               line_pull_o
);
    typedef struct packed {
        logic               req;
        logic [N_RAILS-1:0] mask;
    } resp_t;

    logic [N_SRC-1:0]   src_act;
    logic [N_SRC-1:0]   src_lvl;
    logic [N_SRC-1:0]   src_fall;
    logic [GW-1:0]      src_glitch [N_SRC];
    logic [N_RAILS-1:0] src_mask   [N_SRC];
    logic               pull_q;
    resp_t              out_d, out_q;

    flt_line_drv #(.N_RAILS(N_RAILS)) u_line_drv (
        .clk          (clk),
        .rst_n        (rst_n),
        .rail_fault_i (rail_fault_i),
        .out_mask_i   (line_out_mask_i),
        .pull_o       (pull_q)
    );

    always_comb begin
        src_act[SRC_GPI]     = gpi_en_i & gpi_sel_vld_i;
        src_lvl[SRC_GPI]     = gpi_raw_i;
        src_glitch[SRC_GPI]  = gpi_glitch_i;
        src_mask[SRC_GPI]    = gpi_resp_mask_i;
        src_act[SRC_LINE]    = line_en_i & line_sel_vld_i;
        // own pull is seen as a released (asserted) line
        src_lvl[SRC_LINE]    = line_in_i | pull_q;
        src_glitch[SRC_LINE] = line_glitch_i;
        src_mask[SRC_LINE]   = line_resp_mask_i;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        flt_deglitch #(.GW(GW)) u_dg (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (src_act[g]),
            .tick_i   (tick_i),
            .level_i  (src_lvl[g]),
            .glitch_i (src_glitch[g]),
            .fall_o   (src_fall[g])
        );
    end

    always_comb begin
        out_d.req  = (|src_fall) & ~debug_i;
        out_d.mask = '0;
        if (out_d.req) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (src_fall[s]) out_d.mask = out_d.mask | src_mask[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{req: 1'b0, mask: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign resp_req_o  = out_q.req;
    assign resp_mask_o = out_q.mask;
    assign line_pull_o = pull_q;
endmodule

// File: rtl/flt_share_chk.sv
module flt_share_chk #(
    parameter int unsigned N_RAILS = 16,
    parameter int unsigned GW      = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic               gpi_raw_i,
    input logic               gpi_en_i,
    input logic               gpi_sel_vld_i,
    input logic [GW-1:0]      gpi_glitch_i,
    input logic [N_RAILS-1:0] gpi_resp_mask_i,
    input logic               line_in_i,
    input logic               line_en_i,
    input logic               line_sel_vld_i,
    input logic [GW-1:0]      line_glitch_i,
    input logic [N_RAILS-1:0] line_resp_mask_i,
    input logic [N_RAILS-1:0] line_out_mask_i,
    input logic [N_RAILS-1:0] rail_fault_i,
    input logic               debug_i,
    input logic               resp_req_o,
    input logic [N_RAILS-1:0] resp_mask_o,
    input logic               line_pull_o
);
    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_req_o |-> resp_mask_o == '0); // R4

    AST_PULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rail_fault_i & line_out_mask_i)) |=> line_pull_o); // R5

    AST_PULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(rail_fault_i & line_out_mask_i)) |=> !line_pull_o); // R5

    AST_DEBUG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        debug_i |=> !resp_req_o); // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!(gpi_en_i && gpi_sel_vld_i) && !(line_en_i && line_sel_vld_i)) |=> !resp_req_o); // R6
endmodule

bind flt_share_ctrl flt_share_chk #(.N_RAILS(N_RAILS), .GW(GW)) u_chk (.*);

// File: tb/flt_share_ctrl_tb.sv
module flt_share_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;
    localparam int GWB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic gpi_raw = 1'b1, gpi_en = 1'b0, gpi_sel = 1'b0;
    logic line_en = 1'b0, line_sel = 1'b0, debug = 1'b0, ext_low = 1'b0;
    logic [GWB-1:0] gpi_gl = '0, line_gl = '0;
    logic [NR-1:0] gpi_rm = '0, line_rm = '0, line_om = '0, rail_f = '0;
    logic line_in, resp_req, line_pull;
    logic [NR-1:0] resp_mask;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_in = ~(ext_low | line_pull);

    flt_share_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .gpi_raw_i(gpi_raw), .gpi_en_i(gpi_en), .gpi_sel_vld_i(gpi_sel),
        .gpi_glitch_i(gpi_gl), .gpi_resp_mask_i(gpi_rm),
        .line_in_i(line_in), .line_en_i(line_en), .line_sel_vld_i(line_sel),
        .line_glitch_i(line_gl), .line_resp_mask_i(line_rm),
        .line_out_mask_i(line_om), .rail_fault_i(rail_f), .debug_i(debug),
        .resp_req_o(resp_req), .resp_mask_o(resp_mask), .line_pull_o(line_pull)
    );

    // reference built from the requirements
    logic m_sync [2], m_filt [2];
    int unsigned m_cnt [2];
    logic m_req, m_pull;
    logic [NR-1:0] m_mask;

    function automatic logic [NR-1:0] pick_mask(input logic fg, input logic fl,
                                                 input logic [NR-1:0] a, input logic [NR-1:0] b);
        logic [NR-1:0] r = '0;
        if (fg) r = r | a;
        if (fl) r = r | b;
        return r;
    endfunction

    always @(posedge clk) begin
        logic act [2];
        logic inl [2];
        int unsigned gl [2];
        logic fall [2];
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                m_sync[s] = 1'b1; m_filt[s] = 1'b1; m_cnt[s] = 0;
            end
            m_req = 1'b0; m_mask = '0; m_pull = 1'b0;
        end else begin
            act[0] = gpi_en & gpi_sel;   inl[0] = gpi_raw;           gl[0] = gpi_gl;
            act[1] = line_en & line_sel; inl[1] = line_in | m_pull;  gl[1] = line_gl;
            for (int s = 0; s < 2; s++) begin
                fall[s] = 1'b0;
                if (!act[s]) begin
                    m_filt[s] = 1'b1; m_cnt[s] = 0;
                end else if (m_sync[s] == m_filt[s]) begin
                    m_cnt[s] = 0;
                end else if (tick) begin
                    if (m_cnt[s] >= gl[s]) begin
                        fall[s] = m_filt[s];
                        m_filt[s] = m_sync[s];
                        m_cnt[s] = 0;
                    end else begin
                        m_cnt[s] = m_cnt[s] + 1;
                    end
                end
                m_sync[s] = inl[s];
            end
            m_req  = (fall[0] | fall[1]) & ~debug;
            m_mask = m_req ? pick_mask(fall[0], fall[1], gpi_rm, line_rm) : '0;
            m_pull = |(rail_f & line_om);
        end
    end

    task automatic check(input string req, input logic [NR-1:0] act, input logic [NR-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // advance one cycle, then compare against the reference
    task automatic step();
        @(negedge clk);
        check("R2 req", {15'd0, resp_req}, {15'd0, m_req});
        check("R4 mask", resp_mask, m_mask);
        check("R5 pull", {15'd0, line_pull}, {15'd0, m_pull});
    endtask

    task automatic count_pulses(input int n, output int pulses, output logic [NR-1:0] orm);
        pulses = 0; orm = '0;
        for (int i = 0; i < n; i++) begin
            step();
            if (resp_req) begin pulses++; orm = orm | resp_mask; end
        end
    endtask

    task automatic idle_cfg();
        gpi_raw = 1'b1; ext_low = 1'b0; rail_f = '0; debug = 1'b0;
        gpi_en = 1'b1; gpi_sel = 1'b1; line_en = 1'b1; line_sel = 1'b1;
        tick = 1'b1;
        for (int i = 0; i < 8; i++) step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p;
        logic [NR-1:0] om;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        check("R1 req", {15'd0, resp_req}, '0);
        check("R1 mask", resp_mask, '0);
        check("R1 pull", {15'd0, line_pull}, '0);
        rst_n = 1'b1;

        // R3: short GPI pulse ignored, long one accepted after glitch+2 edges
        gpi_gl = 16'd2; line_gl = 16'd2; gpi_rm = 16'h00F1; line_rm = 16'h8200;
        idle_cfg();
        gpi_raw = 1'b0; step(); step(); gpi_raw = 1'b1;
        count_pulses(10, p, om);
        check("R3 short pulse ignored", p[NR-1:0], 16'd0);
        gpi_raw = 1'b0;
        step(); step(); step();
        check("R3 no early accept", {15'd0, resp_req}, '0);
        step();
        check("R3 accept at glitch+2", {15'd0, resp_req}, 16'd1);
        check("R4 gpi mask", resp_mask, 16'h00F1);
        step();
        check("R2 single cycle", {15'd0, resp_req}, '0);
        // R10: rising filtered level gives no request
        gpi_raw = 1'b1;
        count_pulses(10, p, om);
        check("R10 rise no request", p[NR-1:0], 16'd0);

        // R9: both sources qualify at the same edge
        gpi_gl = 16'd1; line_gl = 16'd1;
        gpi_raw = 1'b0; ext_low = 1'b1;
        count_pulses(8, p, om);
        check("R9 one pulse", p[NR-1:0], 16'd1);
        check("R9 OR mask", om, 16'h82F1);
        gpi_raw = 1'b1; ext_low = 1'b0;
        for (int i = 0; i < 6; i++) step();

        // R7: own pull does not trigger the line monitor; R5 pull follows
        line_gl = 16'd0; line_om = 16'h0004; rail_f = 16'h0004;
        count_pulses(12, p, om);
        check("R7 own pull ignored", p[NR-1:0], 16'd0);
        check("R5 pull held", {15'd0, line_pull}, 16'd1);
        rail_f = 16'h0008;
        for (int i = 0; i < 4; i++) step();
        check("R5 unmasked fault", {15'd0, line_pull}, 16'd0);
        ext_low = 1'b1;
        count_pulses(6, p, om);
        check("R7 external event", p[NR-1:0], 16'd1);
        check("R4 line mask", om, 16'h8200);
        ext_low = 1'b0;
        for (int i = 0; i < 6; i++) step();

        // R8: debug suppresses requests, pull unaffected
        debug = 1'b1; rail_f = 16'h0004; gpi_gl = 16'd0;
        gpi_raw = 1'b0;
        count_pulses(8, p, om);
        check("R8 debug no request", p[NR-1:0], 16'd0);
        check("R8 pull in debug", {15'd0, line_pull}, 16'd1);
        debug = 1'b0; gpi_raw = 1'b1; rail_f = '0;
        for (int i = 0; i < 6; i++) step();

        // R6: disabled or invalid selection ignored
        gpi_sel = 1'b0; line_en = 1'b0;
        gpi_raw = 1'b0; ext_low = 1'b1;
        count_pulses(10, p, om);
        check("R6 disabled no request", p[NR-1:0], 16'd0);
        gpi_raw = 1'b1; ext_low = 1'b0;
        gpi_sel = 1'b1; line_en = 1'b1;
        for (int i = 0; i < 6; i++) step();

        // random phase against the reference
        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 5) == 0) gpi_raw = ~gpi_raw;
            if ($urandom_range(0, 6) == 0) ext_low = ~ext_low;
            if ($urandom_range(0, 40) == 0) begin
                gpi_gl = 16'($urandom_range(0, 3));
                line_gl = 16'($urandom_range(0, 3));
                gpi_rm = 16'($urandom); line_rm = 16'($urandom);
                line_om = 16'($urandom);
            end
            if ($urandom_range(0, 8) == 0) rail_f = 16'($urandom) & 16'($urandom);
            gpi_en = ($urandom_range(0, 15) != 0);
            gpi_sel = ($urandom_range(0, 15) != 0);
            line_en = ($urandom_range(0, 15) != 0);
            line_sel = ($urandom_range(0, 15) != 0);
            debug = ($urandom_range(0, 20) == 0);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule